// File: doc/BRIEF.md
# Binary64 to Unsigned 32-bit Integer Converter

This unit takes one IEEE-754 binary64 operand and a 2-bit rounding-mode select, and produces a 32-bit unsigned integer along with an invalid flag and an inexact flag. It decodes every operand class: zeros, subnormals, normals, infinities and NaNs. For finite values it moves the binary point into place with a shifter and keeps a round bit and a sticky bit. It then rounds the magnitude under the mode chosen for that operation. The overflow test runs on the rounded value.

Any value the 32-bit unsigned range cannot hold returns the all-ones pattern with the invalid flag raised. This covers NaN, infinity, values that are too large, and negative values whose rounded magnitude is nonzero. A negative value that rounds to zero is valid and returns 0. The unit is one pipeline stage. An operand presented with `in_valid` produces its result on the outputs one clock later, and the outputs hold between operations.

Top module: `f64_to_u32_conv`

## Requirements
- R1: An operand accepted with `in_valid` high at a rising edge appears on `result`, `flag_invalid` and `flag_inexact` after that edge, and `out_valid` is high for exactly that cycle. Reset drives `out_valid`, `result` and both flags to 0.
- R2: A finite operand holding an exact integer in [0, 4294967295] returns that integer with both flags low. This includes +0 and 2^32-1.
- R3: Rounding mode 2'b00 rounds to nearest, and a tie goes to the even integer: 1.5 gives 2, 2.5 gives 2, 3.5 gives 4 and 0.5 gives 0.
- R4: Mode 2'b01 rounds toward minus infinity, mode 2'b10 rounds toward plus infinity, and mode 2'b11 truncates toward zero.
- R5: `flag_inexact` is high exactly when the result is valid and some discarded fraction bits are nonzero. This includes subnormal operands.
- R6: NaN and infinity of either sign (exponent field all ones) give `flag_invalid` = 1 and `result` = 32'hFFFFFFFF.
- R7: Overflow is judged after rounding. An operand of 2^32 or more, or one that rounds up to 2^32, is invalid. 4294967295.5 truncated is valid and inexact.
- R8: A negative operand whose rounded magnitude is 0 returns 0 and is valid. -0.0 is exact; any other such operand is inexact. A negative operand whose rounded magnitude is nonzero is invalid.
- R9: An invalid result always reads 32'hFFFFFFFF with `flag_inexact` low.
- R10: While `in_valid` is low, `result` and both flags keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and mode are accepted this cycle |
| operand | input | 64 | binary64 value (sign bit 63, exponent 62:52, fraction 51:0) |
| rmode | input | 2 | Rounding mode: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero |
| out_valid | output | 1 | Result registers loaded on the last edge |
| result | output | 32 | Unsigned integer result, 32'hFFFFFFFF when invalid |
| flag_invalid | output | 1 | Result not representable |
| flag_inexact | output | 1 | Valid result lost nonzero fraction bits |

## Verification
The bench builds the unit with its default parameters: an 11-bit exponent, a 52-bit fraction and a 32-bit result. With these values the boundary operands are real binary64 encodings: 2^31, 2^32-1, 2^32-1 plus one half, 2^32, the smallest subnormal, and small negative fractions. Each operand is paired with more than one rounding mode, so the same value is shown rounding up in one mode and staying put in another. Near 2^32 it also crosses the overflow boundary in one mode and not in another.

// File: rtl/f2u_pkg.sv
package f2u_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_DOWN    = 2'b01,
        RM_UP      = 2'b10,
        RM_ZERO    = 2'b11
    } rmode_e;

endpackage

// File: rtl/f2u_classify.sv
module f2u_classify #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int OP_W  = 1 + EXP_W + FRAC_W,
    localparam int SIG_W = FRAC_W + 1
) (
    input  logic                    [OP_W-1:0]  operand,
    output logic                                sign,
    output logic                                special,
    output logic                                denorm,
    output logic                                frac_nz,
    output logic signed             [EXP_W+1:0] exp_unb,
    output logic                    [SIG_W-1:0] sig
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic signed [EXP_W+1:0] BIAS_S = (EXP_W + 2)'(BIAS);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        sign    = operand[OP_W-1];
        exp_f   = operand[OP_W-2 -: EXP_W];
        frac_f  = operand[FRAC_W-1:0];
        special = &exp_f;
        denorm  = ~|exp_f;
        frac_nz = |frac_f;
        exp_unb = $signed({2'b00, exp_f}) - BIAS_S;
        sig     = {~denorm, frac_f};
    end
endmodule

// File: rtl/f2u_align.sv
module f2u_align #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int OUT_W  = 32,
    localparam int SIG_W = FRAC_W + 1,
    localparam int Q_W   = OUT_W + SIG_W
) (
    input  logic                    denorm,
    input  logic                    frac_nz,
    input  logic signed [EXP_W+1:0] exp_unb,
    input  logic        [SIG_W-1:0] sig,
    output logic        [OUT_W-1:0] int_part,
    output logic                    rbit,
    output logic                    sticky,
    output logic                    too_big
);
    localparam logic signed [EXP_W+1:0] LIM_S = (EXP_W + 2)'(OUT_W);
    localparam logic signed [EXP_W+1:0] NEG1  = -(EXP_W + 2)'(1);
    localparam logic signed [EXP_W+1:0] ONE_S = (EXP_W + 2)'(1);

    logic [Q_W-1:0]   q;
    logic [EXP_W+1:0] sh;

    always_comb begin
        q        = '0;
        sh       = '0;
        int_part = '0;
        rbit     = 1'b0;
        sticky   = 1'b0;
        too_big  = 1'b0;
        if (denorm) begin
            // below one half: only the sticky bit can be set
            sticky = frac_nz;
        end else if (exp_unb >= LIM_S) begin
            too_big = 1'b1;
        end else if (exp_unb < NEG1) begin
            // magnitude below one half, significand nonzero
            sticky = 1'b1;
        end else begin
            sh       = $unsigned(exp_unb + ONE_S);
            q        = {{OUT_W{1'b0}}, sig} << sh;
            int_part = q[Q_W-1 -: OUT_W];
            rbit     = q[SIG_W-1];
            sticky   = |q[SIG_W-2:0];
        end
    end
endmodule

// File: rtl/f2u_round.sv
module f2u_round
    import f2u_pkg::*;
#(
    parameter int OUT_W = 32
) (
    input  logic             sign,
    input  rmode_e           rmode,
    input  logic [OUT_W-1:0] int_part,
    input  logic             rbit,
    input  logic             sticky,
    output logic [OUT_W:0]   mag,
    output logic             lost
);
    logic inc;

    always_comb begin
        lost = rbit | sticky;
        unique case (rmode)
            RM_NEAREST: inc = rbit & (sticky | int_part[0]);
            RM_DOWN:    inc = sign & lost;
            RM_UP:      inc = ~sign & lost;
            default:    inc = 1'b0;
        endcase
        mag = {1'b0, int_part} + {{OUT_W{1'b0}}, inc};
    end
endmodule

// File: rtl/f64_to_u32_conv.sv
module f64_to_u32_conv
    import f2u_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int OUT_W  = 32,
    localparam int OP_W  = 1 + EXP_W + FRAC_W,
    localparam int SIG_W = FRAC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   operand,
    input  logic [1:0]        rmode,
    output logic              out_valid,
    output logic [OUT_W-1:0]  result,
    output logic              flag_invalid,
    output logic              flag_inexact
);
    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] res;
        logic             inv;
        logic             inx;
    } state_t;

    state_t state_d, state_q;

    logic                    sign, special, denorm, frac_nz;
    logic signed [EXP_W+1:0] exp_unb;
    logic        [SIG_W-1:0] sig;
    logic        [OUT_W-1:0] int_part;
    logic                    rbit, sticky, too_big;
    logic        [OUT_W:0]   mag;
    logic                    lost;
    logic                    invalid;

    f2u_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .operand (operand),
        .sign    (sign),
        .special (special),
        .denorm  (denorm),
        .frac_nz (frac_nz),
        .exp_unb (exp_unb),
        .sig     (sig)
    );

    f2u_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_aln (
        .denorm   (denorm),
        .frac_nz  (frac_nz),
        .exp_unb  (exp_unb),
        .sig      (sig),
        .int_part (int_part),
        .rbit     (rbit),
        .sticky   (sticky),
        .too_big  (too_big)
    );

    f2u_round #(.OUT_W(OUT_W)) u_rnd (
        .sign     (sign),
        .rmode    (rmode_e'(rmode)),
        .int_part (int_part),
        .rbit     (rbit),
        .sticky   (sticky),
        .mag      (mag),
        .lost     (lost)
    );

    always_comb begin
        // overflow is judged on the rounded magnitude
        invalid = special | too_big | mag[OUT_W] | (sign & (|mag));
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.inv = invalid;
            state_d.inx = ~invalid & lost;
            state_d.res = invalid ? {OUT_W{1'b1}} : mag[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid    = state_q.vld;
    assign result       = state_q.res;
    assign flag_invalid = state_q.inv;
    assign flag_inexact = state_q.inx;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                          // R1
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                        // R1
    AST_SPECIAL_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&operand[OP_W-2 -: EXP_W])) |=> flag_invalid);      // R6
    AST_NEG_ZERO_OR_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && operand[OP_W-1]) |=> (result == '0 || flag_invalid)); // R8
    AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_invalid |-> (result == '1 && !flag_inexact));               // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flag_invalid)
                       && $stable(flag_inexact)));                        // R10
endmodule

// File: tb/sim_f64_to_u32_conv.sv
module sim_f64_to_u32_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  rmode = 2'b00;
    logic        out_valid, flag_invalid, flag_inexact;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    f64_to_u32_conv u0 (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .operand (operand), .rmode (rmode), .out_valid (out_valid),
        .result (result), .flag_invalid (flag_invalid),
        .flag_inexact (flag_inexact)
    );

    // {operand, mode, expected result, invalid, inexact, requirement number}
    localparam int NV = 32;
    localparam logic [107:0] VEC [NV] = '{
        {64'h3FF0000000000000, 2'b00, 32'h00000001, 1'b0, 1'b0, 8'd2},  // R2 1.0
        {64'h401C000000000000, 2'b11, 32'h00000007, 1'b0, 1'b0, 8'd2},  // R2 7.0
        {64'h41E0000000000000, 2'b00, 32'h80000000, 1'b0, 1'b0, 8'd2},  // R2 2^31
        {64'h41EFFFFFFFE00000, 2'b01, 32'hFFFFFFFF, 1'b0, 1'b0, 8'd2},  // R2 2^32-1
        {64'h0000000000000000, 2'b00, 32'h00000000, 1'b0, 1'b0, 8'd2},  // R2 +0
        {64'h8000000000000000, 2'b01, 32'h00000000, 1'b0, 1'b0, 8'd8},  // R8 -0
        {64'h4004000000000000, 2'b00, 32'h00000002, 1'b0, 1'b1, 8'd3},  // R3 2.5
        {64'h400C000000000000, 2'b00, 32'h00000004, 1'b0, 1'b1, 8'd3},  // R3 3.5
        {64'h3FF8000000000000, 2'b00, 32'h00000002, 1'b0, 1'b1, 8'd3},  // R3 1.5
        {64'h40F0000C00000000, 2'b00, 32'h00010001, 1'b0, 1'b1, 8'd3},  // R3 65536.75
        {64'h3FE0000000000000, 2'b00, 32'h00000000, 1'b0, 1'b1, 8'd3},  // R3 0.5
        {64'h4004000000000000, 2'b01, 32'h00000002, 1'b0, 1'b1, 8'd4},  // R4 down
        {64'h4004000000000000, 2'b10, 32'h00000003, 1'b0, 1'b1, 8'd4},  // R4 up
        {64'h4004000000000000, 2'b11, 32'h00000002, 1'b0, 1'b1, 8'd4},  // R4 zero
        {64'h40F0000C00000000, 2'b01, 32'h00010000, 1'b0, 1'b1, 8'd4},  // R4
        {64'h40F0000C00000000, 2'b10, 32'h00010001, 1'b0, 1'b1, 8'd4},  // R4
        {64'h3FE8000000000000, 2'b10, 32'h00000001, 1'b0, 1'b1, 8'd4},  // R4 0.75 up
        {64'h0000000000000001, 2'b00, 32'h00000000, 1'b0, 1'b1, 8'd5},  // R5 subnormal
        {64'h0000000000000001, 2'b10, 32'h00000001, 1'b0, 1'b1, 8'd5},  // R5 subnormal up
        {64'h7FF0000000000000, 2'b00, 32'hFFFFFFFF, 1'b1, 1'b0, 8'd6},  // R6 +inf
        {64'hFFF0000000000000, 2'b11, 32'hFFFFFFFF, 1'b1, 1'b0, 8'd6},  // R6 -inf
        {64'h7FF8000000000000, 2'b10, 32'hFFFFFFFF, 1'b1, 1'b0, 8'd6},  // R6 NaN
        {64'h41F0000000000000, 2'b11, 32'hFFFFFFFF, 1'b1, 1'b0, 8'd7},  // R7 2^32
        {64'h41EFFFFFFFF00000, 2'b00, 32'hFFFFFFFF, 1'b1, 1'b0, 8'd9},  // R7 R9 tie to 2^32
        {64'h41EFFFFFFFF00000, 2'b11, 32'hFFFFFFFF, 1'b0, 1'b1, 8'd7},  // R7 truncated
        {64'h41EFFFFFFFF00000, 2'b10, 32'hFFFFFFFF, 1'b1, 1'b0, 8'd7},  // R7 up
        {64'hBFD3333333333333, 2'b11, 32'h00000000, 1'b0, 1'b1, 8'd8},  // R8 -0.3 zero
        {64'hBFD3333333333333, 2'b01, 32'hFFFFFFFF, 1'b1, 1'b0, 8'd9},  // R8 R9 -0.3 down
        {64'hBFE0000000000000, 2'b00, 32'h00000000, 1'b0, 1'b1, 8'd8},  // R8 -0.5 nearest
        {64'hBFF0000000000000, 2'b11, 32'hFFFFFFFF, 1'b1, 1'b0, 8'd8},  // R8 -1.0
        {64'hBFE0000000000000, 2'b10, 32'h00000000, 1'b0, 1'b1, 8'd8},  // R8 -0.5 up
        {64'h8000000000000001, 2'b01, 32'hFFFFFFFF, 1'b1, 1'b0, 8'd8}   // R8 -subnormal down
    };

    task automatic check(input bit ok, input string req, input logic [33:0] act,
                         input logic [33:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] keep_res;
        logic [1:0]  keep_flags;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({out_valid, result, flag_invalid, flag_inexact} == '0, "R1 reset",
              {result, flag_invalid, flag_inexact}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 idle", {33'b0, out_valid}, 34'd0);

        for (int i = 0; i < NV; i++) begin
            operand  = VEC[i][107:44];
            rmode    = VEC[i][43:42];
            in_valid = 1'b1;
            @(negedge clk);
            check(out_valid == 1'b1, "R1 out_valid", {33'b0, out_valid}, 34'd1);
            if ({result, flag_invalid, flag_inexact} !== VEC[i][41:8]) begin
                checks++;
                errors++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[i][7:0], i,
                         {result, flag_invalid, flag_inexact}, VEC[i][41:8]);
            end else begin
                checks++;
            end
        end

        // R1: out_valid drops once in_valid goes low; R10: outputs hold
        keep_res   = result;
        keep_flags = {flag_invalid, flag_inexact};
        in_valid = 1'b0;
        operand  = 64'h7FF0000000000000;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 single pulse", {33'b0, out_valid}, 34'd0);
        operand = 64'h4004000000000000;
        repeat (3) @(negedge clk);
        check({result, flag_invalid, flag_inexact} === {keep_res, keep_flags}, "R10 hold",
              {result, flag_invalid, flag_inexact}, {keep_res, keep_flags});

        // R1: back-to-back operations update every cycle
        in_valid = 1'b1;
        operand  = 64'h401C000000000000;
        rmode    = 2'b00;
        @(negedge clk);
        operand  = 64'h3FF0000000000000;
        check(result == 32'd7, "R1 back-to-back first", {2'b0, result}, 34'd7);
        @(negedge clk);
        in_valid = 1'b0;
        check(result == 32'd1 && !flag_inexact && !flag_invalid, "R1 back-to-back second",
              {result, flag_invalid, flag_inexact}, {32'd1, 2'b00});

        // R1: reset mid-run clears the outputs
        rst_n = 1'b0;
        @(negedge clk);
        check({out_valid, result, flag_invalid, flag_inexact} == '0, "R1 re-reset",
              {result, flag_invalid, flag_inexact}, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule